// File: doc/BRIEF.md
# Page-Organized Display RAM Addresser

This block is the device-side front end of a monochrome display controller whose frame memory is organized in pages. Each page is eight pixel rows tall and one byte wide per column. It receives a byte stream in which each byte carries a flag telling whether it is a command or pixel data. It decodes the commands that steer addressing and keeps one column pointer and one page pointer. Each data byte becomes a single write into the frame RAM. Bit 0 of the byte is the top pixel row of the addressed page column, and bit 7 is the bottom row.

Three addressing modes share the same pointers. Horizontal mode fills a window column by column and then moves to the next page. Vertical mode fills a window page by page and then moves to the next column. Page mode stays on one page, and its page and start column are set directly by short commands. The column window and the page window are set by three-byte commands. Commands that do not steer addressing are swallowed without effect, and so are the parameter bytes that belong to them.

Top module: `disp_ram_addr`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the block is in page mode, the column window is 0 to NUM_COLS-1, the page window is 0 to NUM_PAGES-1, both pointers are 0, and wr_en is low.
- R2: A data byte (in_valid=1, in_is_cmd=0) gives, on the next clock, a wr_en pulse one cycle long. That cycle carries wr_data equal to the byte and wr_addr = page*NUM_COLS + column, using the pointers as they stood before that byte. A command byte gives no write.
- R3: Command 0x20 followed by one parameter byte sets the mode from parameter bits [1:0]: 0 is horizontal, 1 is vertical, 2 is page. The value 3 leaves the mode unchanged.
- R4: Command 0x21 followed by a start byte and then an end byte sets the inclusive column window, each value taken modulo NUM_COLS. When the end byte arrives, the column pointer moves to the start.
- R5: Command 0x22 followed by a start byte and then an end byte sets the inclusive page window, each value taken modulo NUM_PAGES. When the end byte arrives, the page pointer moves to the start.
- R6: In page mode, the single byte 0xB0|p (p in bits [2:0]) sets the page pointer. The byte 0x00|n sets column bits [3:0] to n. The byte 0x10|n sets column bits [7:4] to n, truncated to the column width. In the other two modes these bytes have no effect.
- R7: In horizontal mode, after a write the column advances. At the end column (or at the last column) the column returns to the window start and the page advances. At the end page (or the last page) the page returns to the window start.
- R8: In vertical mode, after a write the page advances. At the end page (or the last page) the page returns to the window start and the column advances, wrapping to the window start past the end column.
- R9: In page mode, after a write the column advances and wraps to the column window start past the end column (or the last column). The page never changes on a write.
- R10: The commands 0x81, 0x8D, 0xA8, 0xD3, 0xD5, 0xD8, 0xD9, 0xDA and 0xDB swallow the next command byte as their parameter. Every other unrecognized command byte is swallowed alone. Neither changes a pointer, a window or the mode.
- R11: A data byte that arrives while a command is waiting for its parameters is written normally, and it does not count as a parameter.
- R12: A cycle with in_valid low changes no pointer and gives no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A byte is present this cycle |
| in_is_cmd | input | 1 | 1: the byte is a command or command parameter; 0: pixel data |
| in_byte | input | 8 | Incoming byte |
| wr_en | output | 1 | Frame RAM write strobe |
| wr_addr | output | COL_BITS+PAGE_BITS (10) | Frame RAM byte address, {page, column} |
| wr_data | output | 8 | Byte to write; bit 0 is the top row of the page |

## Verification
A wrong pointer, window or mode can only be seen through wr_addr on the write that follows. The bench therefore follows every accepted byte with a reference model of the pointers and compares each write address in the cycle after its data byte. Some corrupt states can be exposed early or late. A parser that drops or takes one parameter too many desynchronizes the windows, and the next write or the next wrap boundary shows it. A wrong wrap condition shows only when the pointer reaches the window edge. For that reason the directed tests run small windows at the top of the memory and through both wraps.

// File: rtl/dra_pkg.sv
// Shared types and command codes of the display RAM addresser.
package dra_pkg;

    typedef enum logic [1:0] {
        MODE_HORZ = 2'd0,
        MODE_VERT = 2'd1,
        MODE_PAGE = 2'd2
    } addr_mode_e;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_MODE,
        PS_COL_LO,
        PS_COL_HI,
        PS_PG_LO,
        PS_PG_HI,
        PS_SKIP
    } parse_st_e;

    localparam logic [7:0] OP_MODE   = 8'h20;
    localparam logic [7:0] OP_COLWIN = 8'h21;
    localparam logic [7:0] OP_PGWIN  = 8'h22;

    // Unrelated commands known to carry exactly one parameter byte.
    function automatic logic takes_one_param(input logic [7:0] b);
        case (b)
            8'h81, 8'h8D, 8'hA8, 8'hD3, 8'hD5,
            8'hD8, 8'hD9, 8'hDA, 8'hDB: takes_one_param = 1'b1;
            default:                    takes_one_param = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dra_cmd_parser.sv
// Command parser: walks multi-byte addressing commands and emits one-cycle
// update requests. Assumes cmd_stb marks only command-flagged valid bytes;
// data bytes never advance the parameter count.
module dra_cmd_parser
    import dra_pkg::*;
#(
    parameter int COL_BITS  = 7,
    parameter int PAGE_BITS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_stb,
    input  logic [7:0]           cmd_byte,
    output logic                 set_mode,
    output addr_mode_e           mode_val,
    output logic                 set_cwin,
    output logic [COL_BITS-1:0]  cwin_lo,
    output logic [COL_BITS-1:0]  cwin_hi,
    output logic                 set_pwin,
    output logic [PAGE_BITS-1:0] pwin_lo,
    output logic [PAGE_BITS-1:0] pwin_hi,
    output logic                 set_page,
    output logic [PAGE_BITS-1:0] page_val,
    output logic                 set_col_lo,
    output logic                 set_col_hi,
    output logic [3:0]           nib_val
);

    parse_st_e  st, st_n;
    logic [7:0] held;

    // Parser state register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= PS_IDLE;
        else        st <= st_n;
    end

    // Keep the first parameter of a window command until the second arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held <= 8'h00;
        else if (cmd_stb && (st == PS_COL_LO || st == PS_PG_LO))
            held <= cmd_byte;
    end

    assign mode_val = addr_mode_e'(cmd_byte[1:0]);
    assign cwin_lo  = held[COL_BITS-1:0];
    assign cwin_hi  = cmd_byte[COL_BITS-1:0];
    assign pwin_lo  = held[PAGE_BITS-1:0];
    assign pwin_hi  = cmd_byte[PAGE_BITS-1:0];
    assign page_val = PAGE_BITS'(cmd_byte[2:0]);
    assign nib_val  = cmd_byte[3:0];

    // Decode the byte against the current parse state.
    always_comb begin
        st_n       = st;
        set_mode   = 1'b0;
        set_cwin   = 1'b0;
        set_pwin   = 1'b0;
        set_page   = 1'b0;
        set_col_lo = 1'b0;
        set_col_hi = 1'b0;
        if (cmd_stb) begin
            case (st)
                PS_IDLE: begin
                    if (cmd_byte == OP_MODE)              st_n = PS_MODE;
                    else if (cmd_byte == OP_COLWIN)       st_n = PS_COL_LO;
                    else if (cmd_byte == OP_PGWIN)        st_n = PS_PG_LO;
                    else if (cmd_byte[7:3] == 5'b10110)   set_page = 1'b1;
                    else if (cmd_byte[7:4] == 4'h0)       set_col_lo = 1'b1;
                    else if (cmd_byte[7:4] == 4'h1)       set_col_hi = 1'b1;
                    else if (takes_one_param(cmd_byte))   st_n = PS_SKIP;
                end
                PS_MODE: begin
                    set_mode = (cmd_byte[1:0] != 2'd3);
                    st_n     = PS_IDLE;
                end
                PS_COL_LO: st_n = PS_COL_HI;
                PS_COL_HI: begin
                    set_cwin = 1'b1;
                    st_n     = PS_IDLE;
                end
                PS_PG_LO:  st_n = PS_PG_HI;
                PS_PG_HI: begin
                    set_pwin = 1'b1;
                    st_n     = PS_IDLE;
                end
                default:   st_n = PS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dra_pointer_unit.sv
// Pointer unit: holds mode, windows and the column/page pointers, and applies
// the auto-increment and wrap rules. Assumes the memory size is a power of two
// per axis, so every pointer value is a legal location.
module dra_pointer_unit
    import dra_pkg::*;
#(
    parameter int COL_BITS  = 7,
    parameter int PAGE_BITS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    input  logic                 set_mode,
    input  addr_mode_e           mode_val,
    input  logic                 set_cwin,
    input  logic [COL_BITS-1:0]  cwin_lo,
    input  logic [COL_BITS-1:0]  cwin_hi,
    input  logic                 set_pwin,
    input  logic [PAGE_BITS-1:0] pwin_lo,
    input  logic [PAGE_BITS-1:0] pwin_hi,
    input  logic                 set_page,
    input  logic [PAGE_BITS-1:0] page_val,
    input  logic                 set_col_lo,
    input  logic                 set_col_hi,
    input  logic [3:0]           nib_val,
    output logic [COL_BITS-1:0]  col,
    output logic [PAGE_BITS-1:0] page
);

    localparam logic [COL_BITS-1:0]  COL_LAST  = '1;
    localparam logic [PAGE_BITS-1:0] PAGE_LAST = '1;

    addr_mode_e           mode, mode_n;
    logic [COL_BITS-1:0]  cs, ce, cs_n, ce_n, col_n;
    logic [PAGE_BITS-1:0] ps, pe, ps_n, pe_n, page_n;
    logic                 col_hit, page_hit;

    assign col_hit  = (col == ce) || (col == COL_LAST);
    assign page_hit = (page == pe) || (page == PAGE_LAST);

    // Next-state of pointers, windows and mode.
    always_comb begin
        mode_n = mode;
        cs_n   = cs;
        ce_n   = ce;
        ps_n   = ps;
        pe_n   = pe;
        col_n  = col;
        page_n = page;
        if (adv) begin
            case (mode)
                MODE_HORZ: begin
                    if (col_hit) begin
                        col_n  = cs;
                        page_n = page_hit ? ps : page + 1'b1;
                    end else begin
                        col_n = col + 1'b1;
                    end
                end
                MODE_VERT: begin
                    if (page_hit) begin
                        page_n = ps;
                        col_n  = col_hit ? cs : col + 1'b1;
                    end else begin
                        page_n = page + 1'b1;
                    end
                end
                default: col_n = col_hit ? cs : col + 1'b1;
            endcase
        end
        if (set_mode) mode_n = mode_val;
        if (set_cwin) begin
            cs_n  = cwin_lo;
            ce_n  = cwin_hi;
            col_n = cwin_lo;
        end
        if (set_pwin) begin
            ps_n   = pwin_lo;
            pe_n   = pwin_hi;
            page_n = pwin_lo;
        end
        if (mode == MODE_PAGE) begin
            if (set_page)   page_n = page_val;
            if (set_col_lo) col_n  = {col[COL_BITS-1:4], nib_val};
            if (set_col_hi) col_n  = COL_BITS'({nib_val, col[3:0]});
        end
    end

    // State registers with reset defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_PAGE;
            cs   <= '0;
            ce   <= COL_LAST;
            ps   <= '0;
            pe   <= PAGE_LAST;
            col  <= '0;
            page <= '0;
        end else begin
            mode <= mode_n;
            cs   <= cs_n;
            ce   <= ce_n;
            ps   <= ps_n;
            pe   <= pe_n;
            col  <= col_n;
            page <= page_n;
        end
    end

endmodule

// File: rtl/dra_write_port.sv
// Write port: registers the frame RAM strobe, address and data for one cycle
// per data byte. Assumes the pointers given are those before the increment.
module dra_write_port #(
    parameter int COL_BITS  = 7,
    parameter int PAGE_BITS = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_req,
    input  logic [7:0]                     byte_in,
    input  logic [COL_BITS-1:0]            col,
    input  logic [PAGE_BITS-1:0]           page,
    output logic                           wr_en,
    output logic [COL_BITS+PAGE_BITS-1:0]  wr_addr,
    output logic [7:0]                     wr_data
);

    // Register one write per accepted data byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= 8'h00;
        end else begin
            wr_en <= wr_req;
            if (wr_req) begin
                wr_addr <= {page, col};
                wr_data <= byte_in;
            end
        end
    end

endmodule

// File: rtl/disp_ram_addr.sv
// Top of the display RAM addresser: splits the byte stream into commands and
// data, and ties together the parser, the pointer unit and the write port.
// Assumes one byte per valid cycle and no back-pressure.
module disp_ram_addr
    import dra_pkg::*;
#(
    parameter int COL_BITS  = 7,
    parameter int PAGE_BITS = 3,
    localparam int ADDR_BITS = COL_BITS + PAGE_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_is_cmd,
    input  logic [7:0]           in_byte,
    output logic                 wr_en,
    output logic [ADDR_BITS-1:0] wr_addr,
    output logic [7:0]           wr_data
);

    logic                 cmd_stb, data_stb;
    logic                 set_mode, set_cwin, set_pwin, set_page;
    logic                 set_col_lo, set_col_hi;
    addr_mode_e           mode_val;
    logic [COL_BITS-1:0]  cwin_lo, cwin_hi, col_ptr;
    logic [PAGE_BITS-1:0] pwin_lo, pwin_hi, page_val, page_ptr;
    logic [3:0]           nib_val;

    assign cmd_stb  = in_valid && in_is_cmd;
    assign data_stb = in_valid && !in_is_cmd;

    dra_cmd_parser #(.COL_BITS(COL_BITS), .PAGE_BITS(PAGE_BITS)) u_parse (
        .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_byte(in_byte),
        .set_mode(set_mode), .mode_val(mode_val),
        .set_cwin(set_cwin), .cwin_lo(cwin_lo), .cwin_hi(cwin_hi),
        .set_pwin(set_pwin), .pwin_lo(pwin_lo), .pwin_hi(pwin_hi),
        .set_page(set_page), .page_val(page_val),
        .set_col_lo(set_col_lo), .set_col_hi(set_col_hi), .nib_val(nib_val)
    );

    dra_pointer_unit #(.COL_BITS(COL_BITS), .PAGE_BITS(PAGE_BITS)) u_ptr (
        .clk(clk), .rst_n(rst_n), .adv(data_stb),
        .set_mode(set_mode), .mode_val(mode_val),
        .set_cwin(set_cwin), .cwin_lo(cwin_lo), .cwin_hi(cwin_hi),
        .set_pwin(set_pwin), .pwin_lo(pwin_lo), .pwin_hi(pwin_hi),
        .set_page(set_page), .page_val(page_val),
        .set_col_lo(set_col_lo), .set_col_hi(set_col_hi), .nib_val(nib_val),
        .col(col_ptr), .page(page_ptr)
    );

    dra_write_port #(.COL_BITS(COL_BITS), .PAGE_BITS(PAGE_BITS)) u_wport (
        .clk(clk), .rst_n(rst_n), .wr_req(data_stb), .byte_in(in_byte),
        .col(col_ptr), .page(page_ptr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

endmodule

// File: rtl/dra_checker.sv
// Temporal checks on the addresser's ports and pointers, bound into the top.
module dra_checker #(
    parameter int COL_BITS  = 7,
    parameter int PAGE_BITS = 3
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_valid,
    input logic                          in_is_cmd,
    input logic [7:0]                    in_byte,
    input logic                          wr_en,
    input logic [COL_BITS+PAGE_BITS-1:0] wr_addr,
    input logic [7:0]                    wr_data,
    input logic [COL_BITS-1:0]           col_ptr,
    input logic [PAGE_BITS-1:0]          page_ptr
);

    AST_DATA_GIVES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_is_cmd) |=> wr_en); // R2

    AST_CMD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_is_cmd) |=> !wr_en); // R2

    AST_WRITE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_is_cmd) |=> (wr_data == $past(in_byte))); // R2

    AST_ADDR_FROM_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_is_cmd) |=> (wr_addr == {$past(page_ptr), $past(col_ptr)})); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(col_ptr) && $stable(page_ptr) && !wr_en)); // R12

endmodule

bind disp_ram_addr dra_checker #(.COL_BITS(COL_BITS), .PAGE_BITS(PAGE_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_cmd(in_is_cmd),
    .in_byte(in_byte), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .col_ptr(col_ptr), .page_ptr(page_ptr)
);

// File: tb/sim_disp_ram_addr.sv
`timescale 1ns/1ps
module sim_disp_ram_addr;

    localparam int NC = 128;
    localparam int NP = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_is_cmd = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       wr_en;
    logic [9:0] wr_addr;
    logic [7:0] wr_data;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model state
    int m_mode, m_cs, m_ce, m_ps, m_pe, m_col, m_pg, m_pst, m_tmp;
    bit exp_en;
    int exp_addr, exp_data;

    disp_ram_addr u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_cmd(in_is_cmd),
        .in_byte(in_byte), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always #2 clk = ~clk;

    task automatic model_reset();
        m_mode = 2; m_cs = 0; m_ce = NC - 1; m_ps = 0; m_pe = NP - 1;
        m_col = 0; m_pg = 0; m_pst = 0; m_tmp = 0;
    endtask

    task automatic model_advance();
        bit ch, ph;
        ch = (m_col == m_ce) || (m_col == NC - 1);
        ph = (m_pg == m_pe) || (m_pg == NP - 1);
        if (m_mode == 0) begin
            if (ch) begin m_col = m_cs; m_pg = ph ? m_ps : m_pg + 1; end
            else m_col = m_col + 1;
        end else if (m_mode == 1) begin
            if (ph) begin m_pg = m_ps; m_col = ch ? m_cs : m_col + 1; end
            else m_pg = m_pg + 1;
        end else begin
            m_col = ch ? m_cs : m_col + 1;
        end
    endtask

    task automatic model_cmd(input int b);
        case (m_pst)
            0: begin
                if (b == 'h20) m_pst = 1;
                else if (b == 'h21) m_pst = 2;
                else if (b == 'h22) m_pst = 4;
                else if (b >= 'hB0 && b <= 'hB7) begin
                    if (m_mode == 2) m_pg = (b % 8) % NP;
                end else if (b < 16) begin
                    if (m_mode == 2) m_col = (m_col / 16) * 16 + b;
                end else if (b < 32) begin
                    if (m_mode == 2) m_col = ((b % 16) * 16 + m_col % 16) % NC;
                end else if (b == 'h81 || b == 'h8D || b == 'hA8 || b == 'hD3 || b == 'hD5 ||
                             b == 'hD8 || b == 'hD9 || b == 'hDA || b == 'hDB) m_pst = 6;
            end
            1: begin if (b % 4 != 3) m_mode = b % 4; m_pst = 0; end
            2: begin m_tmp = b % NC; m_pst = 3; end
            3: begin m_cs = m_tmp; m_ce = b % NC; m_col = m_cs; m_pst = 0; end
            4: begin m_tmp = b % NP; m_pst = 5; end
            5: begin m_ps = m_tmp; m_pe = b % NP; m_pg = m_ps; m_pst = 0; end
            default: m_pst = 0;
        endcase
    endtask

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One clock: drive a byte, update the model, compare outputs after the edge.
    task automatic step(input bit v, input bit c, input int b, input string tag);
        @(negedge clk);
        in_valid = v; in_is_cmd = c; in_byte = b[7:0];
        exp_en = 1'b0;
        if (v && !c) begin
            exp_en = 1'b1;
            exp_addr = m_pg * NC + m_col;
            exp_data = b % 256;
            model_advance();
        end else if (v) begin
            model_cmd(b % 256);
        end
        @(posedge clk); #1;
        check(wr_en === exp_en, tag, "wr_en", int'(wr_en), int'(exp_en));
        if (exp_en) begin
            check(int'(wr_addr) == exp_addr, tag, "wr_addr", int'(wr_addr), exp_addr);
            check(int'(wr_data) == exp_data, tag, "wr_data", int'(wr_data), exp_data);
        end
    endtask

    task automatic cmd(input int b, input string tag); step(1, 1, b, tag); endtask
    task automatic dat(input int b, input string tag); step(1, 0, b, tag); endtask
    task automatic idle(input string tag); step(0, 0, 0, tag); endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) begin
            @(posedge clk); #1;
            check(wr_en === 1'b0, "R1", "wr_en in reset", int'(wr_en), 0);
        end
        @(negedge clk); rst_n = 1'b1;
        // R1: first writes in page mode from address 0
        dat('hA5, "R1"); dat('h01, "R1"); idle("R12"); dat('h80, "R12");
        // R6: page/nibble commands in page mode
        cmd('hB3, "R6"); cmd('h05, "R6"); cmd('h12, "R6"); dat('h3C, "R6");
        // R9: column wrap within window, page fixed
        cmd('h21, "R4"); cmd(10, "R4"); cmd(12, "R4");
        for (int i = 0; i < 5; i++) dat(i, "R9");
        // R7: horizontal mode with small windows at the memory top
        cmd('h20, "R3"); cmd(0, "R3");
        cmd('h21, "R4"); cmd(126, "R4"); cmd(127, "R4");
        cmd('h22, "R5"); cmd(6, "R5"); cmd(7, "R5");
        for (int i = 0; i < 6; i++) dat('h10 + i, "R7");
        // R8: vertical mode
        cmd('h20, "R3"); cmd(1, "R3");
        cmd('h21, "R4"); cmd(5, "R4"); cmd(6, "R4");
        cmd('h22, "R5"); cmd(2, "R5"); cmd(3, "R5");
        for (int i = 0; i < 5; i++) dat('h20 + i, "R8");
        // R6: page/nibble commands ignored outside page mode
        cmd('hB5, "R6"); cmd('h03, "R6"); cmd('h1F, "R6"); dat('h55, "R6");
        // R3: mode value 3 ignored
        cmd('h20, "R3"); cmd(3, "R3"); dat('h66, "R3"); dat('h67, "R3");
        // R10: swallowed parameters and single unknown commands
        cmd('h20, "R3"); cmd(2, "R3"); cmd('hB1, "R6");
        cmd('h81, "R10"); cmd('h14, "R10"); cmd('hAF, "R10"); cmd('hE3, "R10");
        cmd('hDA, "R10"); cmd('hB6, "R10"); dat('h77, "R10");
        // R11: data inside a pending window command
        cmd('h21, "R11"); dat('h88, "R11"); cmd(40, "R11"); dat('h89, "R11");
        cmd(41, "R11"); dat('h8A, "R11"); dat('h8B, "R11"); dat('h8C, "R11");
        // Mixed random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            int r;
            int b;
            r = $urandom;
            b = $urandom % 256;
            if (r % 5 == 0) b = b % 40;
            step(r % 7 != 0, (r >> 4) % 2 == 1, b, "R2");
        end
        idle("R12");
        finish_run();
    end

endmodule